// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic read and write an external asynchronous static RAM of 8K bytes. A requester presents one single-beat transfer at a time on a valid/ready handshake, with a direction bit, a 13-bit address and a write byte. The controller then runs the memory's select, output-enable and write-strobe lines through a fixed sequence of phases. It returns a one-cycle done pulse when the transfer is complete, and for a read it also returns the captured byte.

Each phase length is a whole number of system-clock cycles. The controller derives it from the memory's nanosecond limits and the clock period, rounding up: access time, output-enable access, cycle time, write-pulse width, data setup, and bus release after a strobe or a deselect. All memory-side outputs come straight from flip-flops, so they change only on clock edges. The data bus is split into an outgoing byte, a driver enable and an incoming byte, and an external pad combines them into the tri-state pin. When no transfer is in progress, the chip enables are deasserted so the memory sits in standby.

Top module: `sram_bridge`

## Requirements
- R1: After reset, the low-true select `mem_ce_n` is 1, the high-true select `mem_ce` is 0, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From that same edge, `mem_addr` carries the request address and the chip is selected (`mem_ce_n`=0, `mem_ce`=1).
- R3: In a read, `mem_oe_n` is 0 and `mem_we_n` is 1 for RD_CYC cycles, where RD_CYC is the largest of the rounded-up access time, output-enable access time and cycle time, plus one capture cycle (9 at defaults). The byte on `mem_dq_i` is captured at the edge that ends the phase. `rsp_rdata` shows that byte, with `rsp_done`=1, RD_CYC edges after acceptance.
- R4: In a write, `mem_oe_n` stays 1 and `mem_we_n` stays 0 for WZ_CYC+DRV_CYC cycles (8 at defaults). This is never fewer than the rounded-up write-pulse width. `mem_dq_oe` rises only after `mem_we_n` has been 0 for WZ_CYC cycles (the rounded-up bus release time, 3 at defaults). It then stays 1 for DRV_CYC cycles: the largest of data setup, the remaining write pulse and the remaining cycle time (5 at defaults).
- R5: `mem_dq_oe` falls at the same edge where `mem_we_n` returns to 1. For one further cycle after that, the chip stays selected and the address is held.
- R6: The address does not change while the chip is selected, so it is stable throughout every strobe.
- R7: After a read, the chip is deselected with `mem_oe_n`=1 for at least HZ_CYC cycles: the rounded-up larger of the deselect and output-enable release times, 3 at defaults. Only after that can a new request be taken, so the earliest next select comes HZ_CYC+1 cycles after the read finishes.
- R8: With no pending request, the chip is left deselected and `req_ready` is 1.
- R9: Every accepted request produces exactly one `rsp_done` pulse, in request order. A write's pulse comes at the edge where `mem_weN` rises, WZ_CYC+DRV_CYC edges after acceptance.
- R10: `mem_oe_n` and `mem_we_n` are never both 0, and `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R11: `req_ready` is 0 from the edge that accepts a request until the controller is idle again. A `req_valid` held during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Byte address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Byte read, valid with a read's done pulse |
| mem_addr | output | ADDR_W (13) | Memory address pins |
| mem_ce_n | output | 1 | Low-true chip select |
| mem_ce | output | 1 | High-true chip select |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_dq_o | output | DATA_W (8) | Byte driven toward the data pins |
| mem_dq_oe | output | 1 | Enable of the data pin driver |
| mem_dq_i | input | DATA_W (8) | Byte seen on the data pins |

## Verification
The stimulus covers:
- Write-then-read of the same location, which shows that the strobe phases really store and return data.
- Reads of both address extremes and of untouched locations, which separate address handling from data handling.
- All-zero, all-one and alternating byte values, which expose stuck or swapped data bits.
- Back-to-back reads and writes in every order, with the valid line held, which test the recovery gap after reads and the single acceptance per request.
- Spaced requests, which test the return to standby.

A nanosecond-resolution memory model flags the following:
- contention on the data lines;
- write pulses or data setup that are too short;
- address motion while the chip is selected;
- read capture before the access time has elapsed, because the model drives unknown data during that window.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_RECOV,
        PH_WR_REL,
        PH_WR_DRV,
        PH_WR_END
    } phase_e;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3 a reloaded phase never finishes in the cycle right after loading a nonzero length
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] pin_data,
    output logic [DATA_W-1:0] held_data
);
    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap_en) hold_d = pin_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign held_data = hold_q;

    // R3 the held byte only moves on a capture strobe
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(held_data));
endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_ACC_NS  = 80,
    parameter int T_OEA_NS  = 40,
    parameter int T_CYC_NS  = 80,
    parameter int T_WP_NS   = 60,
    parameter int T_DS_NS   = 40,
    parameter int T_WREL_NS = 30,
    parameter int T_CREL_NS = 30,
    parameter int T_OREL_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC  = max2(max2(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OEA_NS, CLK_NS)),
                                  ns_to_cyc(T_CYC_NS, CLK_NS)) + 1;
    localparam int WZ_CYC  = max2(ns_to_cyc(T_WREL_NS, CLK_NS), 1);
    localparam int DRV_CYC = max2(max2(ns_to_cyc(T_DS_NS, CLK_NS), ns_to_cyc(T_WP_NS, CLK_NS) - WZ_CYC),
                                  max2(ns_to_cyc(T_CYC_NS, CLK_NS) - WZ_CYC, 1));
    localparam int HZ_CYC  = max2(max2(ns_to_cyc(T_CREL_NS, CLK_NS), ns_to_cyc(T_OREL_NS, CLK_NS)), 1);
    localparam int WP_MIN  = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int MAX_CYC = max2(max2(RD_CYC, WZ_CYC), max2(DRV_CYC, HZ_CYC));
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam int LW      = $clog2(WZ_CYC + DRV_CYC + 2);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              ce;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              done;
    } regs_t;

    regs_t         r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          cap_en;

    sram_phase_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .pin_data  (mem_dq_i),
        .held_data (rsp_rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.ce_n  = 1'b0;
                    r_d.ce    = 1'b1;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.phase = PH_WR_REL;
                        r_d.we_n  = 1'b0;
                        tmr_val   = TW'(WZ_CYC - 1);
                    end else begin
                        r_d.phase = PH_READ;
                        r_d.oe_n  = 1'b0;
                        tmr_val   = TW'(RD_CYC - 1);
                    end
                end
            end
            PH_READ: begin
                if (tmr_exp) begin
                    cap_en    = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.ce    = 1'b0;
                    r_d.phase = PH_RECOV;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(HZ_CYC - 1);
                end
            end
            PH_RECOV: begin
                if (tmr_exp) r_d.phase = PH_IDLE;
            end
            PH_WR_REL: begin
                if (tmr_exp) begin
                    r_d.dq_oe = 1'b1;
                    r_d.phase = PH_WR_DRV;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(DRV_CYC - 1);
                end
            end
            PH_WR_DRV: begin
                if (tmr_exp) begin
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.phase = PH_WR_END;
                end
            end
            PH_WR_END: begin
                r_d.ce_n  = 1'b1;
                r_d.ce    = 1'b0;
                r_d.phase = PH_IDLE;
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.phase == PH_IDLE);
    assign rsp_done  = r_q.done;
    assign mem_addr  = r_q.addr;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_ce    = r_q.ce;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;

    // Length of the current write strobe, for the window checks below.
    logic [LW-1:0] we_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         we_low_q <= '0;
        else if (!mem_we_n) we_low_q <= we_low_q + 1'b1;
        else                we_low_q <= '0;
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    // R10
    drv_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    // R4
    drv_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && we_low_q >= LW'(WZ_CYC)));
    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> we_low_q >= LW'(WP_MIN));
    // R5
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_dq_oe && !mem_ce_n && mem_ce && $stable(mem_addr)));
    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    // R11
    one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !mem_ce_n));
    // R7
    read_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && mem_we_n && $past(!mem_oe_n)) |=> (!req_ready && mem_ce_n));
endmodule

// File: tb/sram_bridge_tb_top.sv
`timescale 1ns/1ps
module sram_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    // Expected phase lengths from the nanosecond limits, rounded up.
    localparam int E_WZ  = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_DRV = 5;  // max(ceil(40/10)=4, ceil(60/10)-3=3, ceil(80/10)-3=5)
    localparam int E_RD  = (80 + CLK_PERIOD - 1) / CLK_PERIOD + 1;
    localparam int E_HZ  = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_WP  = (60 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = 'x;

    sram_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model with timing checks ----------------
    logic [DW-1:0] mmem   [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    realtime t_sel = 0, t_oe = 0, t_addr = 0, t_wl = 0, t_dat = 0, drv_until = 0;
    bit p_sel = 0, p_oe_n = 1, p_we_n = 1, p_dq_oe = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq_o = '0;

    task automatic viol(input string req, input string what);
        chk(1'b0, req, what, 1, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mmem[i] = '0;
            shadow[i] = '0;
        end
        forever begin
            realtime now;
            bit sel, rd, mdrv;
            #1;
            now = $realtime;
            sel = !mem_ce_n && mem_ce;
            if (sel && !p_sel) t_sel = now;
            if (!mem_oe_n && p_oe_n) t_oe = now;
            if (mem_addr != p_addr) begin
                t_addr = now;
                if (sel && p_sel) viol("R6", "address moved while selected");
            end
            rd = sel && !mem_oe_n && mem_we_n;
            if (rd) drv_until = now + 30;
            mdrv = rd || (now < drv_until);
            if (rd && (now - t_sel >= 80) && (now - t_addr >= 80) && (now - t_oe >= 40))
                mem_dq_i = mmem[mem_addr];
            else
                mem_dq_i = 'x;
            if (mdrv && mem_dq_oe) viol("R10", "bus contention");
            if (!mem_we_n && p_we_n) t_wl = now;
            if (mem_dq_oe && (!p_dq_oe || mem_dq_o != p_dq_o)) t_dat = now;
            if (mem_we_n && !p_we_n && p_sel) begin
                if (now - t_wl < 60) viol("R4", "write pulse too short");
                if (now - t_dat < 40) viol("R4", "data setup too short");
                if (!p_dq_oe) viol("R5", "driver off before strobe end");
                else mmem[p_addr] = p_dq_o;
            end
            p_sel = sel; p_oe_n = mem_oe_n; p_we_n = mem_we_n;
            p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_dq_o = mem_dq_o;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            is_rd;
        logic [DW-1:0] data;
        int            acc;
    } exp_t;
    exp_t sb_q[$];

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        e.is_rd = !wr;
        e.acc   = cyc;
        e.data  = wr ? d : shadow[a];
        if (wr) shadow[a] = d;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_ce_n && mem_ce, "R2", "select after accept", {mem_ce_n, mem_ce}, 2'b01);
        chk(mem_addr == a, "R2", "address after accept", mem_addr, a);
        chk(!req_ready, "R11", "ready low while busy", req_ready, 0);
        if (wr) chk(!mem_we_n && mem_oe_n && !mem_dq_oe, "R4", "write strobe start",
                    {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b010);
        else    chk(!mem_oe_n && mem_we_n, "R3", "read strobe start",
                    {mem_oe_n, mem_we_n}, 2'b01);
    endtask

    int wl_cnt = 0, dv_cnt = 0, gap = 0;
    bit after_rd = 0;
    logic [AW-1:0] wr_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9", "done with no request", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.is_rd) begin
                        chk(rsp_rdata === e.data, "R3", "read data", rsp_rdata, e.data);
                        chk(cyc - e.acc - 1 == E_RD, "R3", "read latency", cyc - e.acc - 1, E_RD);
                        after_rd = 1; gap = 0;
                    end else begin
                        chk(cyc - e.acc - 1 == E_WZ + E_DRV, "R9", "write latency",
                            cyc - e.acc - 1, E_WZ + E_DRV);
                    end
                end
            end
            if (!mem_we_n) begin
                wl_cnt++;
                wr_addr = mem_addr;
                if (mem_dq_oe) begin
                    if (dv_cnt == 0)
                        chk(wl_cnt == E_WZ + 1, "R4", "driver start cycle", wl_cnt, E_WZ + 1);
                    dv_cnt++;
                end
            end else if (wl_cnt != 0) begin
                chk(wl_cnt == E_WZ + E_DRV && wl_cnt >= E_WP, "R4", "strobe length",
                    wl_cnt, E_WZ + E_DRV);
                chk(dv_cnt == E_DRV, "R4", "driver length", dv_cnt, E_DRV);
                chk(!mem_dq_oe, "R5", "driver off at strobe end", mem_dq_oe, 0);
                chk(!mem_ce_n && mem_ce && mem_addr == wr_addr, "R5", "select and address held",
                    mem_addr, wr_addr);
                wl_cnt = 0; dv_cnt = 0;
            end
            if (!(!mem_ce_n && mem_ce)) begin
                if (after_rd) gap++;
            end else if (after_rd) begin
                chk(gap >= E_HZ + 1, "R7", "gap after read", gap, E_HZ + 1);
                after_rd = 0;
            end
            if (!mem_oe_n && (!mem_we_n || mem_dq_oe))
                chk(1'b0, "R10", "strobe overlap", {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b011);
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "R9", "watchdog expired", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && !mem_ce, "R1", "deselected in reset", {mem_ce_n, mem_ce}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "strobes idle",
            {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
        chk(req_ready && !rsp_done, "R1", "ready and no done", {req_ready, rsp_done}, 2'b10);

        issue(1, 13'h0000, 8'h5A);
        issue(1, 13'h1FFF, 8'hA5);
        issue(0, 13'h0000, 8'h00);
        issue(0, 13'h1FFF, 8'h00);
        issue(0, 13'h0456, 8'h00);
        issue(1, 13'h0123, 8'hFF);
        issue(0, 13'h0123, 8'h00);
        issue(1, 13'h0123, 8'h00);
        issue(0, 13'h0123, 8'h00);
        for (int i = 0; i < 8; i++) issue(1, AW'(13'h0800 + i * 37), DW'(8'h01 << i));
        for (int i = 7; i >= 0; i--) begin
            issue(0, AW'(13'h0800 + i * 37), 8'h00);
            repeat (i % 3) @(negedge clk);
        end
        issue(0, 13'h1FFF, 8'h00);
        issue(1, 13'h1FFF, 8'h3C);
        issue(0, 13'h1FFF, 8'h00);

        repeat (30) @(negedge clk);
        chk(sb_q.size() == 0, "R9", "all requests completed", sb_q.size(), 0);
        // R8 standby when idle
        chk(mem_ce_n && !mem_ce, "R8", "standby select", {mem_ce_n, mem_ce}, 2'b10);
        chk(req_ready && !mem_dq_oe && mem_oe_n && mem_we_n, "R8", "idle outputs",
            {req_ready, mem_dq_oe, mem_oe_n, mem_we_n}, 4'b1011);
        summary();
    end
endmodule